// File: doc/BRIEF.md
# Execution Unit Error Guard

This block watches the control events around a cipher execution unit with an input FIFO and an output FIFO, and turns illegal conditions into recorded errors. It sees FIFO push and pop strobes with their full and empty flags, writes on the unit's register bus, the decoded register offset and the end-of-operation event. From these it derives six error sources: a bad mode-register write, an access to an unused offset, a data-size write while output data is still pending, an end of operation while input data is still pending, an input FIFO overflow and an output FIFO underflow.

A mask register chooses, per source, whether an error counts. A masked error is dropped completely. An unmasked error sets a sticky status bit and raises the error interrupt. It also moves the unit's control state machine into a halted state, where start requests are refused. Software reads both registers over a simple read/write port, clears status bits by writing ones, and can also use a synchronous soft reset.

The control state machine has three states. ST_IDLE moves to ST_RUN on a start request. ST_RUN returns to ST_IDLE on the end-of-operation event. Any state moves to ST_HALT on an unmasked error. ST_HALT returns to ST_IDLE once every status bit is clear. A soft reset sends any state to ST_IDLE.

Top module: `eu_fault_guard`

## Requirements
- R1: The mask register sits at offset 0 and resets to 0. Each source has one bit: mode error is bit 31, bad offset is bit 30, output-pending-at-size-write is bit 29, input-pending-at-done is bit 28, input overflow is bit 26 and output underflow is bit 25. A 1 disables the source. Every other bit reads 0 and ignores writes, so writing all ones reads back 0xF600_0000.
- R2: The six error events are defined as follows. Mode error is a write to offset 3 whose data has any bit of MODE_RSVD set (default 0xFFFF_FF00). Bad offset is a read or write at any offset other than 0 to 3. Output-pending error is a write to offset 2 while out_empty is 0. Input-pending error is done_evt while in_empty is 0. Overflow is in_push while in_full is 1. Underflow is out_pop while out_empty is 1.
- R3: An unmasked event sets the status bit at the same position as its mask bit, in the status register at offset 1, at the clock edge that samples the event. From that edge err_irq is 1 and halted is 1.
- R4: A masked event leaves the status register, err_irq and halted unchanged.
- R5: Several events in one cycle each set their own status bit when unmasked.
- R6: Status bits are sticky and are cleared by writing 1 at their position to offset 1. A new event for a bit wins over a clear of that bit in the same cycle. err_irq is the OR of all status bits.
- R7: While halted, start_req is ignored. halted falls when all status bits are clear. soft_rst clears all status bits, returns the state machine to ST_IDLE, and keeps the mask.
- R8: The value written to the mask register applies to events from the next cycle on. A mask write changes no status bit that is already set.
- R9: start_req in ST_IDLE enters ST_RUN, where busy is 1. done_evt in ST_RUN returns to ST_IDLE. An unmasked error in any state enters ST_HALT and drops busy.
- R10: rdata is loaded one cycle after rd_en with the register at addr, and is 0 for offsets other than 0 and 1. rdata holds its value in cycles without rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset of status and state |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word offset in the unit window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| in_push | input | 1 | Input FIFO push strobe |
| in_full | input | 1 | Input FIFO full flag |
| in_empty | input | 1 | Input FIFO empty flag |
| out_pop | input | 1 | Output FIFO read strobe |
| out_empty | input | 1 | Output FIFO empty flag |
| done_evt | input | 1 | End-of-operation event |
| start_req | input | 1 | Request to start processing |
| busy | output | 1 | Unit is processing (ST_RUN) |
| halted | output | 1 | Unit is stopped by an error (ST_HALT) |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench builds the block with ADDR_W=3. This gives an eight-offset window, so every legal and every illegal offset can be swept in one pass. The 6-bit effective mask space allows all 64 mask patterns to be crossed with each of the six error sources, with the expected status word, interrupt and halt computed from the bit-position table. Directed sequences then cover same-cycle collisions: several sources at once, a clear racing a new event, and a mask write racing an event.

// File: rtl/eu_fault_pkg.sv
package eu_fault_pkg;
    localparam int NSRC = 6;

    // source index -> bit position in mask and status words
    localparam int SRC_POS [NSRC] = '{31, 30, 29, 28, 26, 25};

    localparam logic [31:0] ERR_FIELDS = 32'hF600_0000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } eu_state_e;
endpackage

// File: rtl/eu_fault_detect.sv
module eu_fault_detect
    import eu_fault_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          MASK_OFS  = 0,
    parameter int          STAT_OFS  = 1,
    parameter int          SIZE_OFS  = 2,
    parameter int          MODE_OFS  = 3,
    parameter logic [31:0] MODE_RSVD = 32'hFFFF_FF00
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              in_push,
    input  logic              in_full,
    input  logic              in_empty,
    input  logic              out_pop,
    input  logic              out_empty,
    input  logic              done_evt,
    output logic [NSRC-1:0]   evt
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(SIZE_OFS);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_OFS);

    logic legal_ofs;
    logic bus_act;

    assign legal_ofs = (addr == A_MASK) || (addr == A_STAT) ||
                       (addr == A_SIZE) || (addr == A_MODE);
    assign bus_act   = wr_en || rd_en;

    always_comb begin
        evt    = '0;
        evt[0] = wr_en && (addr == A_MODE) && ((wdata & MODE_RSVD) != '0);
        evt[1] = bus_act && !legal_ofs;
        evt[2] = wr_en && (addr == A_SIZE) && !out_empty;
        evt[3] = done_evt && !in_empty;
        evt[4] = in_push && in_full;
        evt[5] = out_pop && out_empty;
    end
endmodule

// File: rtl/eu_fault_regs.sv
module eu_fault_regs
    import eu_fault_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int MASK_OFS = 0,
    parameter int STAT_OFS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSRC-1:0]   wsel,
    input  logic [NSRC-1:0]   evt,
    output logic [NSRC-1:0]   mask_q,
    output logic [NSRC-1:0]   stat_q,
    output logic              new_err,
    output logic              all_clear,
    output logic [31:0]       rdata
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    logic            mask_wr;
    logic            stat_wr;
    logic [NSRC-1:0] hit;
    logic [NSRC-1:0] stat_nxt;
    logic [31:0]     mask_view;
    logic [31:0]     stat_view;

    assign mask_wr = wr_en && (addr == A_MASK);
    assign stat_wr = wr_en && (addr == A_STAT);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i]      = evt[i] && !mask_q[i];
        // a fresh event outranks a same-cycle clear
        assign stat_nxt[i] = !soft_rst &&
                             (hit[i] || (stat_q[i] && !(stat_wr && wsel[i])));
    end

    assign new_err   = (|hit) && !soft_rst;
    assign all_clear = (stat_nxt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            stat_q <= stat_nxt;
            if (mask_wr) begin
                mask_q <= wsel;
            end
        end
    end

    always_comb begin
        mask_view = '0;
        stat_view = '0;
        for (int i = 0; i < NSRC; i++) begin
            mask_view[SRC_POS[i]] = mask_q[i];
            stat_view[SRC_POS[i]] = stat_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (addr == A_MASK) begin
                rdata <= mask_view;
            end else if (addr == A_STAT) begin
                rdata <= stat_view;
            end else begin
                rdata <= '0;
            end
        end
    end
endmodule

// File: rtl/eu_fault_fsm.sv
module eu_fault_fsm
    import eu_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic start_req,
    input  logic done_evt,
    input  logic new_err,
    input  logic all_clear,
    output logic busy,
    output logic halted
);
    eu_state_e state_q;
    eu_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = ST_IDLE;
        end else if (new_err) begin
            state_d = ST_HALT;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_req) state_d = ST_RUN;
                ST_RUN:  if (done_evt)  state_d = ST_IDLE;
                ST_HALT: if (all_clear) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy   = 1'b0;
        halted = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  busy   = 1'b1;
            ST_HALT: halted = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/eu_fault_guard.sv
module eu_fault_guard
    import eu_fault_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          MASK_OFS  = 0,
    parameter int          STAT_OFS  = 1,
    parameter int          SIZE_OFS  = 2,
    parameter int          MODE_OFS  = 3,
    parameter logic [31:0] MODE_RSVD = 32'hFFFF_FF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              in_push,
    input  logic              in_full,
    input  logic              in_empty,
    input  logic              out_pop,
    input  logic              out_empty,
    input  logic              done_evt,
    input  logic              start_req,
    output logic              busy,
    output logic              halted,
    output logic              err_irq
);
    logic [NSRC-1:0] evt;
    logic [NSRC-1:0] wsel;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] stat_q;
    logic            new_err;
    logic            all_clear;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            wsel[i] = wdata[SRC_POS[i]];
        end
    end

    eu_fault_detect #(
        .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS), .STAT_OFS(STAT_OFS),
        .SIZE_OFS(SIZE_OFS), .MODE_OFS(MODE_OFS), .MODE_RSVD(MODE_RSVD)
    ) u_detect (
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .in_push(in_push), .in_full(in_full), .in_empty(in_empty),
        .out_pop(out_pop), .out_empty(out_empty), .done_evt(done_evt),
        .evt(evt)
    );

    eu_fault_regs #(
        .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS), .STAT_OFS(STAT_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wsel(wsel), .evt(evt),
        .mask_q(mask_q), .stat_q(stat_q), .new_err(new_err),
        .all_clear(all_clear), .rdata(rdata)
    );

    eu_fault_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .start_req(start_req), .done_evt(done_evt), .new_err(new_err),
        .all_clear(all_clear), .busy(busy), .halted(halted)
    );

    assign err_irq = |stat_q;
endmodule

// File: rtl/eu_fault_guard_chk.sv
module eu_fault_guard_chk
    import eu_fault_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int STAT_OFS = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              start_req,
    input logic              in_push,
    input logic              in_full,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic              busy,
    input logic              halted,
    input logic              err_irq,
    input logic              mask_ovf
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    AST_IRQ_TRACKS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == halted); // R7

    AST_HALT_REFUSES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && start_req) |=> !busy); // R7

    AST_OVF_STOPS_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_push && in_full && !mask_ovf && !soft_rst) |=> (halted && err_irq && !busy)); // R3

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq && !soft_rst && !(wr_en && addr == A_STAT)) |=> err_irq); // R6

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~ERR_FIELDS) == 32'h0); // R1
endmodule

bind eu_fault_guard eu_fault_guard_chk #(
    .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start_req(start_req),
    .in_push(in_push), .in_full(in_full), .wr_en(wr_en), .addr(addr),
    .rdata(rdata), .busy(busy), .halted(halted), .err_irq(err_irq),
    .mask_ovf(mask_q[4])
);

// File: tb/tb_eu_fault_guard.sv
`timescale 1ns/1ps
module tb_eu_fault_guard;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          in_push = 1'b0;
    logic          in_full = 1'b0;
    logic          in_empty = 1'b1;
    logic          out_pop = 1'b0;
    logic          out_empty = 1'b1;
    logic          done_evt = 1'b0;
    logic          start_req = 1'b0;
    logic          busy;
    logic          halted;
    logic          err_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int pos [6] = '{31, 30, 29, 28, 26, 25};

    always #2.5 clk = ~clk;

    eu_fault_guard #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .in_push(in_push), .in_full(in_full), .in_empty(in_empty),
        .out_pop(out_pop), .out_empty(out_empty), .done_evt(done_evt),
        .start_req(start_req), .busy(busy), .halted(halted), .err_irq(err_irq)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(logic [AW-1:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        step();
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic pulse_soft();
        soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
    endtask

    function automatic logic [31:0] spread(logic [5:0] m);
        logic [31:0] r = '0;
        for (int i = 0; i < 6; i++) r[pos[i]] = m[i];
        return r;
    endfunction

    task automatic fire(int s);
        case (s)
            0: begin wr_en = 1'b1; addr = 3'd3; wdata = 32'h0000_0100; end
            1: begin wr_en = 1'b1; addr = 3'd5; wdata = '0; end
            2: begin wr_en = 1'b1; addr = 3'd2; out_empty = 1'b0; end
            3: begin done_evt = 1'b1; in_empty = 1'b0; end
            4: begin in_push = 1'b1; in_full = 1'b1; end
            default: begin out_pop = 1'b1; end
        endcase
        step();
        wr_en = 1'b0; wdata = '0; out_empty = 1'b1; done_evt = 1'b0;
        in_empty = 1'b1; in_push = 1'b0; in_full = 1'b0; out_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        step(); step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        check("R1 reset irq", {31'b0, err_irq}, 32'h0);
        check("R9 reset busy", {31'b0, busy}, 32'h0);
        check("R7 reset halted", {31'b0, halted}, 32'h0);
        bus_rd(3'd0, v); check("R1 reset mask", v, 32'h0);
        bus_rd(3'd1, v); check("R1 reset status", v, 32'h0);

        // R1 reserved bits
        bus_wr(3'd0, 32'hFFFF_FFFF);
        bus_rd(3'd0, v); check("R1 reserved mask bits", v, 32'hF600_0000);
        // R10 rdata holds without rd_en
        bus_wr(3'd0, 32'h0);
        step();
        check("R10 rdata holds", rdata, 32'hF600_0000);
        bus_rd(3'd2, v); check("R10 other offset reads 0", v, 32'h0);

        // R2 legal mode write and offset sweep
        bus_wr(3'd3, 32'h0000_00FF);
        check("R2 legal mode write", {31'b0, err_irq}, 32'h0);
        for (int a = 0; a < 8; a++) begin
            pulse_soft();
            bus_rd(3'(a), v);
            check("R2 offset sweep irq", {31'b0, err_irq}, {31'b0, a >= 4});
        end

        // R3 R4 sweep: every mask pattern against every source
        for (int m = 0; m < 64; m++) begin
            for (int s = 0; s < 6; s++) begin
                logic on;
                pulse_soft();
                bus_wr(3'd0, spread(6'(m)));
                fire(s);
                on = !m[s];
                check(on ? "R3 irq" : "R4 irq", {31'b0, err_irq}, {31'b0, on});
                check(on ? "R3 halted" : "R4 halted", {31'b0, halted}, {31'b0, on});
                bus_rd(3'd1, v);
                check(on ? "R3 status" : "R4 status", v,
                      on ? (32'h1 << pos[s]) : 32'h0);
            end
        end

        // R9 state walk
        pulse_soft();
        bus_wr(3'd0, 32'h0);
        start_req = 1'b1; step(); start_req = 1'b0;
        check("R9 start enters run", {31'b0, busy}, 32'h1);
        done_evt = 1'b1; step(); done_evt = 1'b0;
        check("R9 done leaves run", {31'b0, busy}, 32'h0);
        start_req = 1'b1; step(); start_req = 1'b0;
        fire(4);
        check("R9 error in run drops busy", {31'b0, busy}, 32'h0);
        check("R9 error in run halts", {31'b0, halted}, 32'h1);
        start_req = 1'b1; step(); start_req = 1'b0;
        check("R7 start ignored busy", {31'b0, busy}, 32'h0);
        check("R7 start ignored halted", {31'b0, halted}, 32'h1);

        // R5 simultaneous events
        pulse_soft();
        in_push = 1'b1; in_full = 1'b1; out_pop = 1'b1; done_evt = 1'b1; in_empty = 1'b0;
        step();
        in_push = 1'b0; in_full = 1'b0; out_pop = 1'b0; done_evt = 1'b0; in_empty = 1'b1;
        bus_rd(3'd1, v); check("R5 three sources", v, 32'h1600_0000);

        // R6 partial and full W1C
        bus_wr(3'd1, 32'h0400_0000);
        bus_rd(3'd1, v); check("R6 partial clear", v, 32'h1200_0000);
        check("R7 still halted", {31'b0, halted}, 32'h1);
        bus_wr(3'd1, 32'h1200_0000);
        check("R7 clear releases halt", {31'b0, halted}, 32'h0);
        check("R6 irq follows status", {31'b0, err_irq}, 32'h0);

        // R6 set wins over clear
        fire(4);
        wr_en = 1'b1; addr = 3'd1; wdata = 32'h0400_0000; in_push = 1'b1; in_full = 1'b1;
        step();
        wr_en = 1'b0; wdata = '0; in_push = 1'b0; in_full = 1'b0;
        bus_rd(3'd1, v); check("R6 set beats clear", v, 32'h0400_0000);

        // R7 soft reset releases and keeps mask
        bus_wr(3'd0, 32'h0200_0000);
        pulse_soft();
        check("R7 soft reset halted", {31'b0, halted}, 32'h0);
        bus_rd(3'd1, v); check("R7 soft reset status", v, 32'h0);
        bus_rd(3'd0, v); check("R7 soft reset keeps mask", v, 32'h0200_0000);

        // R8 mask timing
        bus_wr(3'd0, 32'h0);
        wr_en = 1'b1; addr = 3'd0; wdata = 32'h0400_0000; in_push = 1'b1; in_full = 1'b1;
        step();
        wr_en = 1'b0; wdata = '0; in_push = 1'b0; in_full = 1'b0;
        bus_rd(3'd1, v); check("R8 old mask applies same cycle", v, 32'h0400_0000);
        bus_wr(3'd0, 32'hF600_0000);
        bus_rd(3'd1, v); check("R8 mask write keeps status", v, 32'h0400_0000);
        bus_wr(3'd1, 32'h0400_0000);
        fire(4);
        check("R8 new mask applies", {31'b0, err_irq}, 32'h0);
        bus_wr(3'd0, 32'h0);
        bus_rd(3'd1, v); check("R8 unmask sets nothing", v, 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule